// File: doc/BRIEF.md
# Dual-Mode Fixed-Point Multiply-Accumulate Unit

This block is the accumulating half of a fixed-point multiply-accumulate pipeline stage. It keeps one 64-bit accumulator. Each accepted operation multiplies two signed operands and adds the product to the accumulator. The accumulator is treated either as one 64-bit scalar or as two independent 32-bit lanes packed side by side. The new accumulator value is also placed on a 64-bit destination output in the same update. The issuing logic therefore never needs a separate read of the accumulator.

Operations enter on a valid/ready stream. The block never applies back-pressure: `in_ready` is held high, and every cycle with `in_valid` high is an accepted operation. Dependent operations can issue on consecutive cycles, and each one sees the result of the one before it. The destination side carries only a valid qualifier and has no ready input. A consumer must take `dst_data` in the cycle that `dst_valid` is high. The value stays on the bus until the next accepted operation.

The accumulator is never cleared as a side effect of an operation. A new accumulation loop starts with an operation that has the clear control set. That operation loads the plain product instead of the sum.

Top module: `mac_acc_dual`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `dst_data` is zero and `dst_valid` is low. The internal accumulator also resets to zero.
- R2: With `in_mode`=0 (two-lane mode), lane k occupies bits [32k+31:32k] for k = 0 or 1. For each lane, the signed 16-bit values in bits [32k+15:32k] of `in_a` and `in_b` are multiplied, and the product is added to that lane of the accumulator, modulo 2^32.
- R3: In two-lane mode, a carry out of the low lane never reaches the high lane.
- R4: With `in_mode`=1 (wide mode), the signed 32-bit values in bits [31:0] of `in_a` and `in_b` are multiplied, and the 64-bit product is added to the whole accumulator, modulo 2^64.
- R5: When `in_clear`=1 on an accepted operation, the accumulator is loaded with the product alone. The previous accumulator contents are discarded.
- R6: One cycle after an accepted operation, `dst_valid` is high and `dst_data` equals the new accumulator value.
- R7: Operations accepted on consecutive cycles each use the accumulator value left by the operation before them, with no stall.
- R8: In a cycle with `in_valid` low, the accumulator and `dst_data` keep their values, and `dst_valid` is low in the following cycle, whatever is on the operand inputs.
- R9: Operand bits outside the multiplied fields have no effect on the result. In two-lane mode these are bits [31:16] and [63:48]; in wide mode they are bits [63:32].
- R10: `in_ready` is high whenever the block is out of reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation strobe |
| in_ready | output | 1 | Always high; the block takes one operation per cycle |
| in_mode | input | 1 | 0 = two 32-bit lanes, 1 = one 64-bit accumulator |
| in_clear | input | 1 | Load the product instead of accumulating |
| in_a | input | 64 | First operand bus |
| in_b | input | 64 | Second operand bus |
| dst_valid | output | 1 | New accumulator value present on dst_data |
| dst_data | output | 64 | Copy of the accumulator after the last operation |

## Verification
The hardest case to reach is a lane boundary carry. For it to show, the low lane must sit at all ones while an addition pushes it past 2^32 in two-lane mode. The same pattern in wide mode must carry into the upper word. The stimulus reaches this with a clear operation whose product is minus one, followed by a unit product, in each mode. Around that, the bench sweeps every pair from a set of signed corner values. It mixes lanes and modes back to back against an arithmetic model and fills the ignored operand bits with random data.

// File: rtl/mac_acc_pkg.sv
package mac_acc_pkg;
  typedef enum logic {
    MODE_LANES = 1'b0,
    MODE_WIDE  = 1'b1
  } mac_mode_e;
endpackage

// File: rtl/mac_prod_gen.sv
// Builds the addend for one operation: packed lane products or one wide product.
module mac_prod_gen
  import mac_acc_pkg::*;
#(
  parameter int ACC_W = 64,
  parameter int LANES = 2
) (
  input  logic             mode_wide,
  input  logic [ACC_W-1:0] op_a,
  input  logic [ACC_W-1:0] op_b,
  output logic [ACC_W-1:0] prod
);
  localparam int LANE_W = ACC_W / LANES;
  localparam int LMUL_W = LANE_W / 2;
  localparam int WMUL_W = ACC_W / 2;

  logic [ACC_W-1:0] lane_vec;
  logic [ACC_W-1:0] wide_prod;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic signed [LANE_W-1:0] ext_a;
    logic signed [LANE_W-1:0] ext_b;
    logic signed [LANE_W-1:0] lp;
    assign ext_a = {{(LANE_W-LMUL_W){op_a[l*LANE_W+LMUL_W-1]}}, op_a[l*LANE_W +: LMUL_W]};
    assign ext_b = {{(LANE_W-LMUL_W){op_b[l*LANE_W+LMUL_W-1]}}, op_b[l*LANE_W +: LMUL_W]};
    assign lp    = ext_a * ext_b;
    assign lane_vec[l*LANE_W +: LANE_W] = lp;
  end

  logic signed [ACC_W-1:0] wext_a;
  logic signed [ACC_W-1:0] wext_b;
  assign wext_a    = {{(ACC_W-WMUL_W){op_a[WMUL_W-1]}}, op_a[WMUL_W-1:0]};
  assign wext_b    = {{(ACC_W-WMUL_W){op_b[WMUL_W-1]}}, op_b[WMUL_W-1:0]};
  assign wide_prod = wext_a * wext_b;

  always_comb begin
    if (mac_mode_e'(mode_wide) == MODE_WIDE) prod = wide_prod;
    else                                     prod = lane_vec;
  end
endmodule

// File: rtl/mac_seg_adder.sv
// Adder split into lanes; the carry between lanes passes only in wide mode.
module mac_seg_adder
  import mac_acc_pkg::*;
#(
  parameter int ACC_W = 64,
  parameter int LANES = 2
) (
  input  logic             mode_wide,
  input  logic [ACC_W-1:0] x,
  input  logic [ACC_W-1:0] y,
  output logic [ACC_W-1:0] sum
);
  localparam int LANE_W = ACC_W / LANES;

  logic [LANES-1:0] carry;
  logic             join_en;
  assign carry[0] = 1'b0;
  assign join_en  = (mac_mode_e'(mode_wide) == MODE_WIDE);

  for (genvar l = 0; l < LANES; l++) begin : g_seg
    logic cin;
    assign cin = join_en & carry[l];
    if (l < LANES - 1) begin : g_mid
      logic [LANE_W:0] t;
      assign t = {1'b0, x[l*LANE_W +: LANE_W]} + {1'b0, y[l*LANE_W +: LANE_W]}
               + {{LANE_W{1'b0}}, cin};
      assign sum[l*LANE_W +: LANE_W] = t[LANE_W-1:0];
      assign carry[l+1] = t[LANE_W];
    end else begin : g_top
      assign sum[l*LANE_W +: LANE_W] = x[l*LANE_W +: LANE_W] + y[l*LANE_W +: LANE_W]
                                     + {{(LANE_W-1){1'b0}}, cin};
    end
  end
endmodule

// File: rtl/mac_acc_dual.sv
module mac_acc_dual
  import mac_acc_pkg::*;
#(
  parameter int ACC_W = 64,
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_mode,
  input  logic             in_clear,
  input  logic [ACC_W-1:0] in_a,
  input  logic [ACC_W-1:0] in_b,
  output logic             dst_valid,
  output logic [ACC_W-1:0] dst_data
);
  localparam int LANE_W = ACC_W / LANES;
  localparam int LMUL_W = LANE_W / 2;
  localparam int WMUL_W = ACC_W / 2;

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] dst_q;
  logic             dval_q;
  logic [ACC_W-1:0] prod;
  logic [ACC_W-1:0] base;
  logic [ACC_W-1:0] next_acc;

  assign in_ready = 1'b1;

  mac_prod_gen #(.ACC_W(ACC_W), .LANES(LANES)) u_prod (
    .mode_wide (in_mode),
    .op_a      (in_a),
    .op_b      (in_b),
    .prod      (prod)
  );

  assign base = in_clear ? '0 : acc_q;

  mac_seg_adder #(.ACC_W(ACC_W), .LANES(LANES)) u_add (
    .mode_wide (in_mode),
    .x         (base),
    .y         (prod),
    .sum       (next_acc)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q  <= '0;
      dst_q  <= '0;
      dval_q <= 1'b0;
    end else begin
      dval_q <= in_valid;
      if (in_valid) begin
        acc_q <= next_acc;
        dst_q <= next_acc;
      end
    end
  end

  assign dst_valid = dval_q;
  assign dst_data  = dst_q;

  // Reference products for the checks below, taken straight from the ports.
  logic signed [LANE_W-1:0] chk_hi_prod;
  logic signed [ACC_W-1:0]  chk_wide_prod;
  always_comb begin
    chk_hi_prod   = LANE_W'($signed(in_a[LANE_W +: LMUL_W])) * LANE_W'($signed(in_b[LANE_W +: LMUL_W]));
    chk_wide_prod = ACC_W'($signed(in_a[WMUL_W-1:0])) * ACC_W'($signed(in_b[WMUL_W-1:0]));
  end

  assert_mirror_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dst_valid |-> dst_data == acc_q);
  assert_valid_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> dst_valid);
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(dst_data) && !dst_valid));
  assert_lane_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_clear && !in_mode) |=> dst_data[ACC_W-1 -: LANE_W] == $past(chk_hi_prod));
  assert_wide_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_clear && in_mode) |=> dst_data == $past(chk_wide_prod));
  assert_ready_R10: assert property (@(posedge clk) disable iff (!rst_n) in_ready);
endmodule

// File: tb/tb_mac_acc_dual.sv
module tb_mac_acc_dual;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        in_mode = 1'b0;
  logic        in_clear = 1'b0;
  logic [63:0] in_a = '0;
  logic [63:0] in_b = '0;
  logic        dst_valid;
  logic [63:0] dst_data;

  int checks = 0;
  int errors = 0;
  logic [63:0] m_acc = '0;

  always #2.5 clk = ~clk;

  mac_acc_dual dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_mode(in_mode), .in_clear(in_clear), .in_a(in_a), .in_b(in_b),
    .dst_valid(dst_valid), .dst_data(dst_data)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] model(input logic wide, input logic clr,
                                        input logic [63:0] acc, input logic [63:0] a,
                                        input logic [63:0] b);
    logic [63:0] r;
    if (wide) begin
      longint pa = longint'($signed(a[31:0]));
      longint pb = longint'($signed(b[31:0]));
      r = (clr ? 64'd0 : acc) + 64'(pa * pb);
    end else begin
      for (int l = 0; l < 2; l++) begin
        int la = int'($signed(a[l*32 +: 16]));
        int lb = int'($signed(b[l*32 +: 16]));
        r[l*32 +: 32] = (clr ? 32'd0 : acc[l*32 +: 32]) + 32'(la * lb);
      end
    end
    return r;
  endfunction

  // Drives one operation at a falling edge and checks it at the next one.
  task automatic op(input string req, input logic wide, input logic clr,
                    input logic [63:0] a, input logic [63:0] b);
    in_valid = 1'b1; in_mode = wide; in_clear = clr; in_a = a; in_b = b;
    m_acc = model(wide, clr, m_acc, a, b);
    @(negedge clk);
    chk(req, dst_data, m_acc);
    chk({req, " valid"}, {63'd0, dst_valid}, 64'd1);
  endtask

  task automatic idle_op();
    in_valid = 1'b0;
    in_a = {$urandom, $urandom};
    in_b = {$urandom, $urandom};
    in_clear = 1'b1;
    @(negedge clk);
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    logic [15:0] c16 [8];
    logic [31:0] c32 [8];
    logic [63:0] held;
    c16 = '{16'h0000, 16'h0001, 16'hFFFF, 16'h0002, 16'h7FFF, 16'h8000, 16'h1234, 16'hFED4};
    c32 = '{32'h0, 32'h1, 32'hFFFFFFFF, 32'h7, 32'h7FFFFFFF, 32'h80000000, 32'h12345678, 32'hFFFE7961};

    repeat (3) @(negedge clk);
    chk("R1 reset data", dst_data, 64'd0);
    chk("R1 reset valid", {63'd0, dst_valid}, 64'd0);
    chk("R10 ready", {63'd0, in_ready}, 64'd1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset", dst_data, 64'd0);
    // R1: accumulator is zero: a zero-product accumulate returns zero
    op("R1 acc zero", 1'b0, 1'b0, 64'd0, 64'd0);

    // R2 R7 R9: lane sweep, back to back, random unused bits
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++)
        op("R2 R7 R9 lane sweep", 1'b0, (i == 0 && j == 0),
           {16'($urandom), c16[i], 16'($urandom), c16[j]},
           {16'($urandom), c16[j], 16'($urandom), c16[i]});

    // R4 R7 R9: wide sweep continuing on the same accumulator
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++)
        op("R4 R7 R9 wide sweep", 1'b1, 1'b0,
           {32'($urandom), c32[i]}, {32'($urandom), c32[j]});

    // R3: low lane at all ones, then +1 must not reach the high lane
    op("R3 R5 lane preload", 1'b0, 1'b1, 64'h0000_0000_0000_0001, 64'h0000_0000_0000_FFFF);
    chk("R3 preload value", dst_data, 64'h0000_0000_FFFF_FFFF);
    op("R3 lane carry cut", 1'b0, 1'b0, 64'h0000_0000_0000_0001, 64'h0000_0000_0000_0001);
    chk("R3 high lane untouched", dst_data, 64'h0000_0000_0000_0000);
    // same pattern in wide mode carries through
    op("R4 R5 wide preload", 1'b1, 1'b1, 64'h0000_0000_FFFF_FFFF, 64'h0000_0000_0000_0001);
    op("R4 wide carry", 1'b1, 1'b0, 64'h0000_0000_0000_0001, 64'h0000_0000_0000_0001);
    chk("R4 wide wrap to zero", dst_data, 64'd0);

    // R5: clear discards a nonzero accumulator
    op("R5 build", 1'b1, 1'b0, 64'h0000_0000_0001_0000, 64'h0000_0000_0001_0000);
    op("R5 clear load", 1'b0, 1'b1, 64'h0000_0003_0000_0005, 64'h0000_0007_0000_FFFE);
    chk("R5 clear value", dst_data, 64'h0000_0015_FFFF_FFF6);

    // R8: idle cycles with junk operands change nothing
    held = dst_data;
    for (int k = 0; k < 4; k++) begin
      idle_op();
      chk("R8 hold data", dst_data, held);
      chk("R8 valid low", {63'd0, dst_valid}, 64'd0);
    end
    op("R8 acc kept", 1'b0, 1'b0, 64'd0, 64'd0);
    chk("R8 acc value", dst_data, held);
    // R6: result appears the cycle after issue
    op("R6 mirror", 1'b1, 1'b0, 64'h0000_0000_0000_0002, 64'h0000_0000_0000_0003);
    in_valid = 1'b0;
    @(negedge clk);
    chk("R6 pulse ends", {63'd0, dst_valid}, 64'd0);
    chk("R10 ready", {63'd0, in_ready}, 64'd1);
    report();
  end
endmodule